// File: doc/BRIEF.md
# Sticky Interface Mode Detector

This block decides, once per power-up, which of three control protocols a small 8-bit DAC setting register obeys. After power-on reset it assumes the increment-only pulse protocol. It then watches a chip-select line and a data/direction line and moves to a different protocol the first time either line is seen low. A low chip-select selects the 3-wire serial protocol. A low direction line, while chip-select is still high, selects the up/down pulse protocol. Every move is one-way. Only a new power-on reset brings the block back to the increment-only state.

Both watched lines arrive asynchronously, so each one passes through its own synchroniser chain before the block looks at it. The 2-bit mode code steers the register datapath elsewhere on the chip. The block also produces the enable for the serial data output driver. That driver is off in both pulse protocols and during shutdown. Shutdown never changes the selected protocol.

Top module: `ifmode_sel`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it rises, `mode` is 2'b00 (increment-only pulse) and `sdo_en` is 0.
- R2: With `cs_n_in` and `dir_in` both held high, `mode` stays 2'b00 for any number of cycles.
- R3: A low on `cs_n_in` seen before rising edge k puts `mode` at 2'b10 (serial) after rising edge k+2. It then stays 2'b10 until the next power-on reset, whatever the inputs do.
- R4: In increment-only mode, a low on `dir_in` seen before edge k while `cs_n_in` is high puts `mode` at 2'b01 (up/down pulse) after edge k+2. It then never returns to 2'b00 before a reset.
- R5: From up/down mode, a low on `cs_n_in` moves `mode` to 2'b10 with the same three-edge latency.
- R6: `mode` never takes the value 2'b11, and no transition leads from serial mode or up/down mode back to increment-only mode without a reset.
- R7: When `cs_n_in` and `dir_in` fall in the same cycle in increment-only mode, `mode` goes straight to 2'b10.
- R8: `sdo_en` is 0 whenever `mode` is not 2'b10. In serial mode, `sdo_en` is 1 exactly when the synchronised chip-select (two edges after `cs_n_in`) is low and `sleep_n` is high.
- R9: Driving `sleep_n` low forces `sdo_en` to 0 at once. It does not change `mode` or block a mode change.
- R10: A low lasting a single clock cycle on either watched input is enough to trigger its transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cs_n_in | input | 1 | Raw chip-select, active low, asynchronous to clk |
| dir_in | input | 1 | Raw data / up-down direction line, asynchronous to clk |
| sleep_n | input | 1 | Shutdown, active low |
| mode | output | 2 | 00 increment-only pulse, 01 up/down pulse, 10 serial |
| sdo_en | output | 1 | Enable for the serial data output driver |

## Verification
The hardest cases to reach from the ports are the ones that test stickiness and priority, because each needs its own power-on cycle. One is a one-cycle direction pulse followed later by chip-select activity. Another is both lines falling on the same edge. The stimulus therefore runs several reset epochs. Each epoch drives one ordering of first lows and then toggles both inputs and `sleep_n` freely to show that the mode never moves back. The expected mode and driver enable come from a per-cycle model of the two-stage synchroniser latency.

// File: rtl/ifmode_sel.sv
module ifmode_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       cs_n_in,
  input  logic       dir_in,
  input  logic       sleep_n,
  output logic [1:0] mode,
  output logic       sdo_en
);

  localparam logic [1:0] M_INC  = 2'b00;
  localparam logic [1:0] M_UPDN = 2'b01;
  localparam logic [1:0] M_SER  = 2'b10;
  localparam int         TOP    = SYNC_STAGES - 1;

  logic [TOP:0] cs_pipe, dir_pipe;
  logic         cs_low, dir_low;
  logic [1:0]   mode_nx;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cs_pipe  <= '1;
      dir_pipe <= '1;
    end else begin
      cs_pipe  <= {cs_pipe[TOP-1:0], cs_n_in};
      dir_pipe <= {dir_pipe[TOP-1:0], dir_in};
    end
  end

  assign cs_low  = ~cs_pipe[TOP];
  assign dir_low = ~dir_pipe[TOP];

  always_comb begin
    mode_nx = mode;
    case (mode)
      M_INC:   if (cs_low) mode_nx = M_SER;
               else if (dir_low) mode_nx = M_UPDN;
      M_UPDN:  if (cs_low) mode_nx = M_SER;
      default: mode_nx = M_SER;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) mode <= M_INC;
    else        mode <= mode_nx;
  end

  assign sdo_en = (mode == M_SER) & cs_low & sleep_n;

endmodule

// File: rtl/ifmode_sel_chk.sv
module ifmode_sel_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sleep_n,
  input logic [1:0] mode,
  input logic       sdo_en,
  input logic       cs_low,
  input logic       dir_low
);

  assert_reset_inc_R1: assert property (@(posedge clk) disable iff (!por_n)
    !$past(por_n) |-> (mode == 2'b00));

  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b00 && !cs_low && !dir_low) |=> (mode == 2'b00));

  assert_ser_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b10) |=> (mode == 2'b10));

  assert_dir_to_updn_R4: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b00 && !cs_low && dir_low) |=> (mode == 2'b01));

  assert_updn_no_back_R6: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b01) |=> (mode != 2'b00));

  assert_no_code11_R6: assert property (@(posedge clk) disable iff (!por_n)
    mode != 2'b11);

  assert_cs_wins_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cs_low && mode != 2'b10) |=> (mode == 2'b10));

  assert_pulse_hiz_R8: assert property (@(posedge clk) disable iff (!por_n)
    (mode != 2'b10) |-> !sdo_en);

  assert_sleep_off_R9: assert property (@(posedge clk) disable iff (!por_n)
    !sleep_n |-> !sdo_en);

endmodule

bind ifmode_sel ifmode_sel_chk u_chk (
  .clk(clk), .por_n(por_n), .sleep_n(sleep_n), .mode(mode),
  .sdo_en(sdo_en), .cs_low(cs_low), .dir_low(dir_low)
);

// File: tb/tb_ifmode_sel.sv
`timescale 1ns/1ps
module tb_ifmode_sel;
  logic clk = 0, por_n = 0, cs_n_in = 1, dir_in = 1, sleep_n = 1;
  logic [1:0] mode;
  logic sdo_en;
  int checks = 0, failures = 0;
  bit done = 0;

  logic [1:0] exp_mode_q[$];
  logic       exp_sdo_q[$];
  string      tag_q[$];

  logic [1:0] m_mode = 0;
  logic m_cs1 = 1, m_cs2 = 1, m_d1 = 1, m_d2 = 1;

  ifmode_sel dut (.clk(clk), .por_n(por_n), .cs_n_in(cs_n_in), .dir_in(dir_in),
                  .sleep_n(sleep_n), .mode(mode), .sdo_en(sdo_en));

  always #5 clk = ~clk;

  task automatic step(input logic cs, input logic dr, input logic slp, input logic rst_n, input string tag);
    @(negedge clk); #1;
    cs_n_in = cs; dir_in = dr; sleep_n = slp; por_n = rst_n;
    if (!rst_n) begin
      m_mode = 0; m_cs1 = 1; m_cs2 = 1; m_d1 = 1; m_d2 = 1;
    end else begin
      if (m_mode == 2'b00) begin
        if (!m_cs2) m_mode = 2'b10;
        else if (!m_d2) m_mode = 2'b01;
      end else if (m_mode == 2'b01 && !m_cs2) m_mode = 2'b10;
      m_cs2 = m_cs1; m_d2 = m_d1; m_cs1 = cs; m_d1 = dr;
    end
    exp_mode_q.push_back(m_mode);
    exp_sdo_q.push_back((m_mode == 2'b10) && !m_cs2 && slp && rst_n);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_mode_q.size() > 0) begin
        logic [1:0] em; logic es; string t;
        em = exp_mode_q.pop_front(); es = exp_sdo_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (mode !== em || sdo_en !== es) begin
          failures++;
          $display("FAIL %s: mode=%b sdo_en=%b expected mode=%b sdo_en=%b", t, mode, sdo_en, em, es);
        end
      end
    end
  end

  task automatic epoch_reset();
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, "R1");
  endtask

  initial begin
    epoch_reset();
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, "R2");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, "R9");
    step(1, 0, 1, 1, "R10");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, "R4");
    for (int i = 0; i < 6; i++) step(1, i[0], i[1], 1, "R6");
    step(0, 1, 1, 1, "R5");
    step(0, 1, 1, 1, "R5");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, "R8");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, "R9");
    for (int i = 0; i < 8; i++) step(i[0], i[1], 1, 1, "R8");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, "R3");

    epoch_reset();
    step(1, 1, 1, 1, "R1");
    step(0, 1, 0, 1, "R10");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, "R3");
    for (int i = 0; i < 4; i++) step(i[0], 1, 1, 1, "R8");

    epoch_reset();
    step(1, 1, 1, 1, "R1");
    step(0, 0, 1, 1, "R7");
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, "R7");

    epoch_reset();
    step(1, 0, 0, 1, "R9");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, "R9");
    for (int i = 0; i < 8; i++) step(1, i[1], 1, 1, "R6");

    step(1, 1, 1, 1, "R6");
    step(1, 1, 1, 1, "R6");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule